// File: doc/BRIEF.md
# ATM Path/Circuit Lookup Matcher

This block holds a small table of 64-bit entries and searches every entry at once for the header fields of an incoming cell. A search key carries a 16-bit circuit identifier, a path identifier of 12 bits (8 bits when the narrow-path option is set) and four extra bits. When both identifiers match an entry, the block reports a circuit hit. When only the path identifier matches and that entry has an all-ones circuit field, the entry acts as a path-wide wildcard and the block reports a path hit on a separate output, with the match-found output also high.

The upper half of each entry is the tag that is compared. The lower half is the 32-bit result word, which is returned on a hit and never compared. A mask register removes chosen tag bits from the comparison. Entries are loaded through a plain write port. A result appears one clock after a search request and stays on the outputs until the next request.

Top module: `atm_cam_matcher`

## Requirements
- R1: After reset, match_found, path_match, match_index and match_word are zero, the mask is zero, and every entry is empty, so no search hits until an entry has been written.
- R2: Key bit k is compared with entry bit 32+k. The circuit identifier is key 15:0 against entry 47:32, the path identifier is key 27:16 against entry 59:48, and the extra bits are key 31:28 against entry 63:60. Entry bits 31:0 are never compared.
- R3: A circuit hit, where every compared tag bit equals the key, gives match_found=1, path_match=0, match_word=entry[31:0] and match_index=the entry's index.
- R4: A path hit needs entry bits 47:32 to be 16'hFFFF and every compared bit in 63:48 to equal the key, with no circuit hit anywhere in the table. It gives match_found=1 and path_match=1, together with that entry's word and index.
- R5: A circuit hit takes priority over any path hit, whatever their indices.
- R6: When several entries hit with the same kind of match, the lowest index wins.
- R7: When mask bit k is 1, key bit k and entry bit 32+k are left out of both the circuit comparison and the path comparison.
- R8: When narrow_path is 1, key bits 27:24 and entry bits 59:56 are left out of the comparison.
- R9: The outputs change only in the cycle after srch_valid is high and are held at all other times.
- R10: A search with no hit gives match_found=0, path_match=0, match_index=0 and match_word=0.
- R11: A write replaces all 64 bits of the entry at wr_addr and marks it valid. A search issued on any later cycle sees the new contents.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Write one table entry |
| wr_addr | input | $clog2(DEPTH) | Index of the entry to write |
| wr_data | input | 64 | Entry: tag in 63:32, result word in 31:0 |
| mask_wr | input | 1 | Load the mask register |
| mask_data | input | 32 | Mask value; a 1 excludes key bit k / entry bit 32+k |
| narrow_path | input | 1 | Use an 8-bit path identifier |
| srch_valid | input | 1 | Search request |
| srch_key | input | 32 | Search key: circuit 15:0, path 27:16, extra 31:28 |
| match_found | output | 1 | A hit of either kind |
| path_match | output | 1 | The hit is a path-wildcard hit |
| match_index | output | $clog2(DEPTH) | Index of the winning entry |
| match_word | output | 32 | Result word of the winning entry |

## Verification
The case hardest to reach from the ports is a key that hits a wildcard entry at a low index and a full-circuit entry at a higher index in the same search, since the stronger kind of match must win over the lower index. The bench places a wildcard entry and a circuit entry with the same path identifier on opposite sides of the table and searches for the circuit. It also searches with a changed circuit field to confirm that the wildcard then wins. It repeats the full sweep with the mask and the narrow-path option applied to key bits that it deliberately corrupts.

// File: rtl/atm_cam_pkg.sv
package atm_cam_pkg;
  localparam int TAG_W   = 32;
  localparam int WORD_W  = 32;
  localparam int ENTRY_W = TAG_W + WORD_W;
  localparam logic [TAG_W-1:0] PATH_FIELD   = 32'hFFFF_0000;
  localparam logic [TAG_W-1:0] NARROW_DROP  = 32'h0F00_0000;
  localparam logic [15:0]      WILDCARD_VCI = 16'hFFFF;
endpackage

// File: rtl/cam_store.sv
module cam_store
  import atm_cam_pkg::*;
#(
  parameter int DEPTH = 16,
  localparam int AW = $clog2(DEPTH)
) (
  input  logic                          clk,
  input  logic                          rst,
  input  logic                          wr_en,
  input  logic [AW-1:0]                 wr_addr,
  input  logic [ENTRY_W-1:0]            wr_data,
  output logic [DEPTH-1:0][TAG_W-1:0]   tags,
  output logic [DEPTH-1:0][WORD_W-1:0]  words,
  output logic [DEPTH-1:0]              valid
);
  always_ff @(posedge clk) begin
    if (wr_en) begin
      tags[wr_addr]  <= wr_data[ENTRY_W-1:WORD_W];
      words[wr_addr] <= wr_data[WORD_W-1:0];
    end
  end

  always_ff @(posedge clk) begin
    if (rst)        valid <= '0;
    else if (wr_en) valid[wr_addr] <= 1'b1;
  end
endmodule

// File: rtl/cam_compare.sv
module cam_compare
  import atm_cam_pkg::*;
#(
  parameter int DEPTH = 16
) (
  input  logic [DEPTH-1:0][TAG_W-1:0] tags,
  input  logic [DEPTH-1:0]            valid,
  input  logic [TAG_W-1:0]            key,
  input  logic [TAG_W-1:0]            care,
  output logic [DEPTH-1:0]            circ_hit,
  output logic [DEPTH-1:0]            path_hit
);
  for (genvar i = 0; i < DEPTH; i++) begin : g_entry
    logic [TAG_W-1:0] diff;
    assign diff        = (tags[i] ^ key) & care;
    assign circ_hit[i] = valid[i] && (diff == '0);
    assign path_hit[i] = valid[i] && ((diff & PATH_FIELD) == '0)
                         && (tags[i][15:0] == WILDCARD_VCI);
  end
endmodule

// File: rtl/hit_select.sv
module hit_select #(
  parameter int DEPTH = 16,
  localparam int AW = $clog2(DEPTH)
) (
  input  logic [DEPTH-1:0] hits,
  output logic             any,
  output logic [AW-1:0]    idx
);
  always_comb begin
    any = |hits;
    idx = '0;
    for (int i = DEPTH - 1; i >= 0; i--) begin
      if (hits[i]) idx = AW'(i);
    end
  end
endmodule

// File: rtl/atm_cam_matcher.sv
module atm_cam_matcher
  import atm_cam_pkg::*;
#(
  parameter int DEPTH = 16,
  localparam int AW = $clog2(DEPTH)
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               wr_en,
  input  logic [AW-1:0]      wr_addr,
  input  logic [ENTRY_W-1:0] wr_data,
  input  logic               mask_wr,
  input  logic [TAG_W-1:0]   mask_data,
  input  logic               narrow_path,
  input  logic               srch_valid,
  input  logic [TAG_W-1:0]   srch_key,
  output logic               match_found,
  output logic               path_match,
  output logic [AW-1:0]      match_index,
  output logic [WORD_W-1:0]  match_word
);
  logic [DEPTH-1:0][TAG_W-1:0]  tags;
  logic [DEPTH-1:0][WORD_W-1:0] words;
  logic [DEPTH-1:0]             valid, circ_hit, path_hit;
  logic [TAG_W-1:0]             mask_q, care;
  logic                         circ_any, path_any;
  logic [AW-1:0]                circ_idx, path_idx;

  always_ff @(posedge clk) begin
    if (rst)          mask_q <= '0;
    else if (mask_wr) mask_q <= mask_data;
  end

  assign care = ~mask_q & (narrow_path ? ~NARROW_DROP : '1);

  cam_store #(.DEPTH(DEPTH)) u_store (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .tags(tags), .words(words), .valid(valid)
  );

  cam_compare #(.DEPTH(DEPTH)) u_cmp (
    .tags(tags), .valid(valid), .key(srch_key), .care(care),
    .circ_hit(circ_hit), .path_hit(path_hit)
  );

  hit_select #(.DEPTH(DEPTH)) u_sel_circ (.hits(circ_hit), .any(circ_any), .idx(circ_idx));
  hit_select #(.DEPTH(DEPTH)) u_sel_path (.hits(path_hit), .any(path_any), .idx(path_idx));

  always_ff @(posedge clk) begin
    if (rst) begin
      match_found <= 1'b0;
      path_match  <= 1'b0;
      match_index <= '0;
      match_word  <= '0;
    end else if (srch_valid) begin
      if (circ_any) begin
        match_found <= 1'b1;
        path_match  <= 1'b0;
        match_index <= circ_idx;
        match_word  <= words[circ_idx];
      end else if (path_any) begin
        match_found <= 1'b1;
        path_match  <= 1'b1;
        match_index <= path_idx;
        match_word  <= words[path_idx];
      end else begin
        match_found <= 1'b0;
        path_match  <= 1'b0;
        match_index <= '0;
        match_word  <= '0;
      end
    end
  end

  assert_path_implies_found_R4: assert property (@(posedge clk) disable iff (rst)
    path_match |-> match_found);

  assert_hold_R9: assert property (@(posedge clk) disable iff (rst)
    !$past(srch_valid) |-> ($stable(match_found) && $stable(path_match)
                            && $stable(match_index) && $stable(match_word)));

  assert_miss_zero_R10: assert property (@(posedge clk) disable iff (rst)
    !match_found |-> (match_word == '0 && match_index == '0 && !path_match));

  assert_reset_clear_R1: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (!match_found && !path_match));
endmodule

// File: tb/tb_atm_cam_matcher.sv
module tb_atm_cam_matcher;
  localparam int DEPTH = 16;
  localparam int AW = $clog2(DEPTH);

  logic clk = 0, rst = 1;
  logic wr_en = 0, mask_wr = 0, narrow_path = 0, srch_valid = 0;
  logic [AW-1:0] wr_addr = '0;
  logic [63:0] wr_data = '0;
  logic [31:0] mask_data = '0, srch_key = '0;
  logic match_found, path_match;
  logic [AW-1:0] match_index;
  logic [31:0] match_word;

  int checks = 0, errors = 0;
  logic [63:0] tbl [DEPTH];
  logic [DEPTH-1:0] tvalid = '0;
  logic [31:0] tmask = '0;
  logic tnarrow = 0;

  always #10 clk = ~clk;

  atm_cam_matcher #(.DEPTH(DEPTH)) dut (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .mask_wr(mask_wr), .mask_data(mask_data), .narrow_path(narrow_path),
    .srch_valid(srch_valid), .srch_key(srch_key), .match_found(match_found),
    .path_match(path_match), .match_index(match_index), .match_word(match_word)
  );

  function automatic logic [37:0] model(input logic [31:0] key);
    logic [31:0] care;
    care = ~tmask & (tnarrow ? 32'hF0FF_FFFF : 32'hFFFF_FFFF);
    for (int i = 0; i < DEPTH; i++)
      if (tvalid[i] && (((tbl[i][63:32] ^ key) & care) == 0))
        return {1'b1, 1'b0, 4'(i), tbl[i][31:0]};
    for (int i = 0; i < DEPTH; i++)
      if (tvalid[i] && tbl[i][47:32] == 16'hFFFF &&
          (((tbl[i][63:48] ^ key[31:16]) & care[31:16]) == 0))
        return {1'b1, 1'b1, 4'(i), tbl[i][31:0]};
    return '0;
  endfunction

  task automatic check(input string req, input logic [37:0] exp);
    logic [37:0] got;
    got = {match_found, path_match, match_index, match_word};
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  task automatic wr(input int a, input logic [63:0] d);
    @(negedge clk);
    wr_en = 1; wr_addr = AW'(a); wr_data = d;
    @(negedge clk);
    wr_en = 0;
    tbl[a] = d; tvalid[a] = 1'b1;
  endtask

  task automatic set_mask(input logic [31:0] m);
    @(negedge clk);
    mask_wr = 1; mask_data = m;
    @(negedge clk);
    mask_wr = 0; tmask = m;
  endtask

  task automatic search(input logic [31:0] key);
    @(negedge clk);
    srch_valid = 1; srch_key = key;
    @(negedge clk);
    srch_valid = 0;
  endtask

  task automatic search_check(input string req, input logic [31:0] key);
    search(key);
    check(req, model(key));
  endtask

  function automatic logic [63:0] mk(input logic [3:0] ex, input logic [11:0] vpi,
                                     input logic [15:0] vci, input logic [31:0] w);
    return {ex, vpi, vci, w};
  endfunction

  initial begin
    #3000000;
    errors++; checks++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    logic [37:0] hold;
    repeat (3) @(negedge clk);
    rst = 0;
    check("R1 reset outputs", '0);
    search(32'h0000_0000);
    check("R1 empty table no hit", '0);
    search(32'h0001_FFFF);
    check("R1 R10 empty table miss", '0);

    for (int i = 0; i < DEPTH; i++)
      wr(i, mk(4'h0, 12'(i + 1), (i % 4 == 3) ? 16'hFFFF : 16'(16'h0100 + i),
               32'hA000_0000 + 32'(i) * 32'h0001_0011));
    for (int i = 0; i < DEPTH; i++) begin
      search_check("R3 R11 circuit sweep", tbl[i][63:32]);
      search_check("R4 R10 altered circuit field", {tbl[i][63:48], 16'h5A5A});
      search_check("R2 extra bits compared", {4'h9, tbl[i][59:32]});
    end

    wr(2, mk(4'h0, 12'h0AB, 16'hFFFF, 32'hCAFE_0002));
    wr(9, mk(4'h0, 12'h0AB, 16'h1234, 32'hCAFE_0009));
    search(32'h00AB_1234);
    check("R5 circuit beats lower path", {1'b1, 1'b0, 4'd9, 32'hCAFE_0009});
    search(32'h00AB_7777);
    check("R4 wildcard hit", {1'b1, 1'b1, 4'd2, 32'hCAFE_0002});

    wr(4, mk(4'h3, 12'h321, 16'h0042, 32'hBEEF_0004));
    wr(11, mk(4'h3, 12'h321, 16'h0042, 32'hBEEF_000B));
    search(32'h3321_0042);
    check("R6 lowest index wins", {1'b1, 1'b0, 4'd4, 32'hBEEF_0004});
    wr(6, mk(4'h0, 12'h077, 16'hFFFF, 32'h1111_0006));
    wr(13, mk(4'h0, 12'h077, 16'hFFFF, 32'h1111_000D));
    search(32'h0077_0001);
    check("R6 lowest path index", {1'b1, 1'b1, 4'd6, 32'h1111_0006});

    wr(7, {32'h0055_0101, 32'hDDDD_0007});
    wr(8, {32'h0055_0101, 32'hEEEE_0008});
    search(32'h0055_0101);
    check("R2 low bits not compared", {1'b1, 1'b0, 4'd7, 32'hDDDD_0007});

    search(32'hF321_0042);
    check("R7 unmasked extra mismatch", model(32'hF321_0042));
    set_mask(32'hF000_0000);
    search(32'hF321_0042);
    check("R7 masked extra bits", {1'b1, 1'b0, 4'd4, 32'hBEEF_0004});
    set_mask(32'h0000_00FF);
    search(32'h00AB_12FF);
    check("R7 masked circuit bits", {1'b1, 1'b0, 4'd9, 32'hCAFE_0009});
    for (int i = 0; i < DEPTH; i++) search_check("R7 masked sweep", tbl[i][63:32] ^ 32'h0000_00C3);
    set_mask(32'h0000_0000);

    search(32'h0F01_0100);
    check("R8 wide path mismatch", model(32'h0F01_0100));
    @(negedge clk); narrow_path = 1; tnarrow = 1;
    search(32'h0F01_0100);
    check("R8 narrow path ignores 27:24", {1'b1, 1'b0, 4'd0, tbl[0][31:0]});
    for (int i = 0; i < DEPTH; i++) search_check("R8 narrow sweep", tbl[i][63:32] ^ 32'h0500_0000);
    @(negedge clk); narrow_path = 0; tnarrow = 0;

    search(32'h00AB_1234);
    hold = {match_found, path_match, match_index, match_word};
    @(negedge clk); srch_key = 32'h0000_0000;
    set_mask(32'hFFFF_FFFF);
    repeat (3) @(negedge clk);
    check("R9 held without request", hold);
    set_mask(32'h0000_0000);
    search(32'hDEAD_BEEF);
    check("R10 miss clears", '0);

    wr(9, mk(4'h0, 12'h0CD, 16'h4321, 32'h9999_0009));
    search(32'h00AB_1234);
    check("R11 overwrite removes old tag", {1'b1, 1'b1, 4'd2, 32'hCAFE_0002});
    search(32'h00CD_4321);
    check("R11 overwrite new tag", {1'b1, 1'b0, 4'd9, 32'h9999_0009});

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule